// File: doc/BRIEF.md
# Serial Core Run-State and Error Status Controller

This block is the control and status part of a serial-bus engine. Software reaches it through 32-bit register writes. It keeps the engine's run state (reset, run or pause) together with a valid flag. Software polls that flag to learn when a requested state has taken effect. A separate register forces the engine back to reset.

On the error side it collects single-cycle event pulses from the bus engine into two groups. The first group is seven sticky status conditions. The second group is four error flags, and each flag has its own enable bit. The block reduces all of these to one error code. Any enabled flag takes precedence. If no enabled flag is set, the most urgent status condition is reported.

The bus engine, the FIFOs and the bit-clock divider sit outside this block. Their event lines come straight in as input pulses.

Top module: `sercore_ctrl`

Register word addresses on `wrAddr`: 0 = state request, 1 = software reset, 2 = master status, 3 = error flags, 4 = error-flag enable.

## Requirements
- R1: After reset the state is reset (`curState` = 0), `stateValid` = 1, `errCode` = 0 and all error-flag enables are 0.
- R2: The state request field is `wrData[2:0]`, with codes 0 = reset, 1 = run and 3 = pause. An accepted request drops `stateValid` for exactly SETTLE cycles (default 2). After that `stateValid` returns to 1 and `curState` shows the new state. `curState` never shows 2 while valid.
- R3: A request with code 4 to 7 is ignored. Any state request written while `stateValid` is 0 is also ignored.
- R4: To leave pause for reset, software writes code 2 to the state register twice, with no other state-register write in between. The first write leaves the core in pause with `stateValid` high. The second write starts the move to reset. Code 2 has no effect in reset or run. Any other state write in between cancels the first write of 2.
- R5: Writing to the software-reset register with `wrData[0]` = 1 forces the reset state through the same SETTLE handshake. This works from any state, even while `stateValid` is 0. A write with `wrData[0]` = 0 is ignored.
- R6: Each bit of `evtStatus` sets a sticky status bit. Any write to the master status register clears all seven bits, whatever the data. If an event and a clearing write arrive in the same cycle, the event bit stays set.
- R7: Each bit of `evtFlag` sets a sticky flag held at register bits 5:2. A write to the flag register clears the flags whose `wrData[5:2]` bit is 1. A write to the enable register loads the enable mask from `wrData[5:2]`.
- R8: `errCode` is 1 when any flag with its enable bit set is active. Otherwise, if status bit i is the lowest set bit, `errCode` is 2+i. The bit order is: 0 invalid read address, 1 generic failure, 2 arbitration lost, 3 bus error, 4 invalid write, 5 NACK, 6 invalid tag. With nothing set, `errCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| evtStatus | input | 7 | Status event pulses, bit index = priority (0 most urgent) |
| evtFlag | input | 4 | Error-flag event pulses |
| curState | output | 2 | Current run state code |
| stateValid | output | 1 | State reached and stable |
| errCode | output | 4 | Prioritised error code |

## Verification
The state handshake is exercised with one legal request per state, with illegal codes, and with requests that land inside the settle window. These show whether the core filters requests by code and by the valid flag, and whether the valid flag drops for the right number of cycles. The pause exit is driven three ways: a single write of 2, a write of 2 followed by an unrelated write, and a proper pair. These separate the completed pair from a stray first write. The error code is driven with one status bit at a time, with mixed bits, and with flags before and after enabling. A status event that coincides with a clearing write checks which of the two wins.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int ADDR_W = 3;
  localparam int N_STATUS = 7;
  localparam int N_FLAG = 4;
  localparam int FLAG_LSB = 2;
  localparam int CODE_W = 4;

  localparam logic [ADDR_W-1:0] A_STATE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SWRST  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd4;

  localparam logic [1:0] ST_RESET = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_PAUSE = 2'd3;
  localparam logic [2:0] REQ_PAIR = 3'd2;

  typedef struct packed {
    logic              clrStatus;
    logic              clrFlags;
    logic              ldEnable;
    logic [N_FLAG-1:0] fieldData;
  } errStrobe_t;
endpackage

// File: rtl/sc_state_ctrl.sv
module sc_state_ctrl
  import sc_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic [1:0]        curState,
  output logic              stateValid,
  output errStrobe_t        strobes
);
  localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(SETTLE - 1);

  logic [CNT_W-1:0] settleCnt;
  logic [1:0]       target;
  logic             armed;
  logic             stWr, swRst, legalReq, pairReq, pairDone;
  logic [2:0]       reqCode;
  logic             unusedHi;

  assign unusedHi = ^wrData[31:FLAG_LSB+N_FLAG];
  assign reqCode  = wrData[2:0];
  assign stWr     = wrEn && (wrAddr == A_STATE) && stateValid;
  assign swRst    = wrEn && (wrAddr == A_SWRST) && wrData[0];
  assign legalReq = stWr && (reqCode == {1'b0, ST_RESET} || reqCode == {1'b0, ST_RUN} ||
                             reqCode == {1'b0, ST_PAUSE});
  assign pairReq  = stWr && (reqCode == REQ_PAIR) && (curState == ST_PAUSE);
  assign pairDone = pairReq && armed;

  always_comb begin
    strobes.clrStatus = wrEn && (wrAddr == A_STATUS);
    strobes.clrFlags  = wrEn && (wrAddr == A_FLAG);
    strobes.ldEnable  = wrEn && (wrAddr == A_ENABLE);
    strobes.fieldData = wrData[FLAG_LSB +: N_FLAG];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState   <= ST_RESET;
      stateValid <= 1'b1;
      target     <= ST_RESET;
      settleCnt  <= '0;
      armed      <= 1'b0;
    end else if (swRst) begin
      target     <= ST_RESET;
      stateValid <= 1'b0;
      settleCnt  <= CNT_START;
      armed      <= 1'b0;
    end else if (legalReq || pairDone) begin
      target     <= pairDone ? ST_RESET : reqCode[1:0];
      stateValid <= 1'b0;
      settleCnt  <= CNT_START;
      armed      <= 1'b0;
    end else if (pairReq) begin
      armed <= 1'b1;
    end else if (stWr) begin
      armed <= 1'b0;
    end else if (!stateValid) begin
      if (settleCnt == '0) begin
        curState   <= target;
        stateValid <= 1'b1;
      end else begin
        settleCnt <= settleCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_err_path.sv
module sc_err_path
  import sc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  errStrobe_t          strobes,
  input  logic [N_STATUS-1:0] evtStatus,
  input  logic [N_FLAG-1:0]   evtFlag,
  output logic [CODE_W-1:0]   errCode
);
  logic [N_STATUS-1:0] statusBits;
  logic [N_FLAG-1:0]   flagBits;
  logic [N_FLAG-1:0]   flagEnable;
  logic [N_FLAG-1:0]   flagClr;

  assign flagClr = strobes.clrFlags ? strobes.fieldData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusBits <= '0;
      flagBits   <= '0;
      flagEnable <= '0;
    end else begin
      statusBits <= (strobes.clrStatus ? '0 : statusBits) | evtStatus;
      flagBits   <= (flagBits & ~flagClr) | evtFlag;
      if (strobes.ldEnable) flagEnable <= strobes.fieldData;
    end
  end

  always_comb begin
    errCode = '0;
    for (int i = N_STATUS - 1; i >= 0; i--) begin
      if (statusBits[i]) errCode = CODE_W'(i + 2);
    end
    if (|(flagBits & flagEnable)) errCode = CODE_W'(1);
  end
endmodule

// File: rtl/sercore_ctrl.sv
module sercore_ctrl
  import sc_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [6:0]        evtStatus,
  input  logic [3:0]        evtFlag,
  output logic [1:0]        curState,
  output logic              stateValid,
  output logic [3:0]        errCode
);
  errStrobe_t strobes;

  sc_state_ctrl #(.SETTLE(SETTLE)) u_state (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curState(curState), .stateValid(stateValid), .strobes(strobes)
  );

  sc_err_path u_err (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtStatus(evtStatus),
    .evtFlag(evtFlag), .errCode(errCode)
  );
endmodule

// File: rtl/sc_checker.sv
module sc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  wrAddr,
  input logic [31:0] wrData,
  input logic [6:0]  evtStatus,
  input logic [1:0]  curState,
  input logic        stateValid,
  input logic [3:0]  errCode
);
  a_r2_no_spontaneous_change: assert property (@(posedge clk) disable iff (!rstN)
    (stateValid && !wrEn) |=> (stateValid && $stable(curState)));

  a_r2_never_code_two: assert property (@(posedge clk) disable iff (!rstN)
    stateValid |-> (curState != 2'd2));

  a_r3_high_code_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stateValid && wrEn && wrAddr == 3'd0 && wrData[2]) |=> (stateValid && $stable(curState)));

  a_r5_swreset_drops_valid: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd1 && wrData[0]) |=> !stateValid);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|evtStatus) |=> (errCode != 4'd0));

  a_r6_sticky_error: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 4'd0 && !wrEn) |=> (errCode != 4'd0));
endmodule

bind sercore_ctrl sc_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .evtStatus(evtStatus), .curState(curState), .stateValid(stateValid), .errCode(errCode)
);

// File: tb/tb_sercore_ctrl.sv
module tb_sercore_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [6:0]  evtStatus = '0;
  logic [3:0]  evtFlag = '0;
  logic [1:0]  curState;
  logic        stateValid;
  logic [3:0]  errCode;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sercore_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtStatus(evtStatus), .evtFlag(evtFlag), .curState(curState),
    .stateValid(stateValid), .errCode(errCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle of stimulus, registered on the posedge between two negedges.
  task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d,
                       input logic [6:0] es, input logic [3:0] ef);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d; evtStatus = es; evtFlag = ef;
    @(negedge clk);
    wrEn = 1'b0; evtStatus = '0; evtFlag = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic goState(input logic [1:0] s);
    wr(3'd0, {30'd0, s});
    idle(2);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk("R1 state", curState, 0);
    chk("R1 valid", stateValid, 1);
    chk("R1 errCode", errCode, 0);
  endtask

  task automatic t_handshake;
    wr(3'd0, 32'd1);
    chk("R2 valid low cycle1", stateValid, 0);
    idle(1);
    chk("R2 valid low cycle2", stateValid, 0);
    idle(1);
    chk("R2 valid back", stateValid, 1);
    chk("R2 state run", curState, 1);
    wr(3'd0, 32'd5);
    chk("R3 code5 valid", stateValid, 1);
    chk("R3 code5 state", curState, 1);
    wr(3'd0, 32'd3);
    wr(3'd0, 32'd1);
    idle(1);
    chk("R3 busy write ignored valid", stateValid, 1);
    chk("R3 busy write ignored state", curState, 3);
  endtask

  task automatic t_pause_exit;
    wr(3'd0, 32'd2);
    chk("R4 single write valid", stateValid, 1);
    chk("R4 single write pause", curState, 3);
    wr(3'd0, 32'd2);
    chk("R4 pair starts", stateValid, 0);
    idle(2);
    chk("R4 pair reaches reset", curState, 0);
    chk("R4 pair valid", stateValid, 1);
    goState(2'd3);
    wr(3'd0, 32'd2);
    wr(3'd0, 32'd1);
    idle(2);
    chk("R4 cancelled pair goes run", curState, 1);
    wr(3'd0, 32'd2);
    chk("R4 code2 in run ignored valid", stateValid, 1);
    chk("R4 code2 in run ignored state", curState, 1);
    goState(2'd3);
    wr(3'd0, 32'd2);
    chk("R4 no stale arm", curState, 3);
    wr(3'd0, 32'd6);
    wr(3'd0, 32'd2);
    chk("R4 other write cancels arm", stateValid, 1);
    chk("R4 still pause", curState, 3);
  endtask

  task automatic t_swreset;
    wr(3'd1, 32'd0);
    chk("R5 zero write ignored", stateValid, 1);
    chk("R5 zero write state", curState, 3);
    wr(3'd1, 32'd1);
    chk("R5 valid drops", stateValid, 0);
    idle(2);
    chk("R5 reset reached", curState, 0);
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd1);
    idle(2);
    chk("R5 swreset during settle", curState, 0);
    chk("R5 swreset during settle valid", stateValid, 1);
  endtask

  task automatic t_status;
    for (int i = 0; i < 7; i++) begin
      drive(1'b0, 3'd0, 32'd0, 7'(1 << i), 4'd0);
      chk("R8 single status bit", errCode, i + 2);
      wr(3'd2, 32'hFFFF_FFFF);
      chk("R6 clear any data", errCode, 0);
    end
    drive(1'b0, 3'd0, 32'd0, 7'b100_1000, 4'd0);
    chk("R8 mixed bits lowest wins", errCode, 5);
    idle(3);
    chk("R6 sticky", errCode, 5);
    drive(1'b1, 3'd2, 32'd0, 7'b010_0000, 4'd0);
    chk("R6 event wins over clear", errCode, 7);
    wr(3'd2, 32'd0);
    chk("R6 cleared", errCode, 0);
  endtask

  task automatic t_flags;
    drive(1'b0, 3'd0, 32'd0, 7'b000_0100, 4'b0010);
    chk("R7 disabled flag hidden", errCode, 4);
    wr(3'd4, 32'h3C);
    chk("R8 enabled flag first", errCode, 1);
    drive(1'b0, 3'd0, 32'd0, 7'd0, 4'b0001);
    wr(3'd3, 32'h08);
    chk("R7 partial clear keeps other", errCode, 1);
    wr(3'd3, 32'h04);
    chk("R7 flags cleared", errCode, 4);
    drive(1'b0, 3'd0, 32'd0, 7'd0, 4'b1000);
    wr(3'd4, 32'h1C);
    chk("R7 enable mask off", errCode, 4);
    wr(3'd3, 32'h3C);
    wr(3'd2, 32'd0);
    chk("R7 all clear", errCode, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_handshake();
    t_pause_exit();
    t_swreset();
    t_status();
    t_flags();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule